// File: doc/BRIEF.md
# Clock Output Gating and Select Unit

This unit sits between a set of free-running internal clocks and the chip's clock output pins. Each general output passes its source clock through a per-output gate. A cleared enable parks that output at a driven low level instead of floating it, which lets unused loads be silenced. Two chip-wide controls act on every output at once: a high-impedance control that releases all pins for board testing, and a bypass control that makes every output copy the reference input so the synthesizer is taken out of the path.

A dedicated super-I/O output carries either a base clock or that clock halved by a toggle flop. A change of selection is applied only when both candidate clocks are low. The unit also publishes a 5-bit frequency code for a downstream synthesizer. The code comes either from four strap pins, captured once after reset with the top bit forced to zero, or from five register bits when an override is set.

All clocks are handled as levels sampled by the fast unit clock `clk_i`, so every gate decision and every output is registered.

Top module: `ckg_top`

## Requirements
- R1: While reset is asserted, every clock output is low, every output-enable (`*_oe_o`) is 1 and `fs_code_o` is 0. After reset, every gate is enabled and the super-I/O output runs at the halved rate.
- R2: With its enable set and both global controls off, `clk_o[k]` equals the level `src_clk_i[k]` had one `clk_i` cycle earlier.
- R3: With its enable cleared, `clk_o[k]` stays at 0 while its `clk_oe_o[k]` stays at 1.
- R4: An enable change is taken only while the output's source clock is low. Every high pulse seen on an output is therefore exactly as long as its source's high phase, whatever the timing of enable changes.
- R5: One cycle after `hiz_i` is 1, every `*_oe_o` is 0 and every clock output is 0. This holds even when `bypass_i` is also 1, because `hiz_i` has priority.
- R6: With `hiz_i`=0 and `bypass_i`=1, every clock output equals the level of `ref_clk_i` one cycle earlier, and the enables have no effect.
- R7: With the applied half-select at 0, the super-I/O output follows `sio_base_i`. At 1, it carries a clock of half that rate, made by toggling on each rising edge of `sio_base_i`. The select resets to 1.
- R8: A change of `sio_half_i` is applied only in a cycle where both `sio_base_i` and the halved clock are low. As a result, no super-I/O high pulse is shorter than one high phase of the base clock.
- R9: With `fs_ovr_i`=0, `fs_code_o` is {0, latched straps}, so bit 4 is 0. With `fs_ovr_i`=1, `fs_code_o` equals `fs_reg_i`. Either source appears at the output one cycle after it is selected.
- R10: `strap_i` is captured in the first cycle after reset. Later changes of `strap_i` do not affect `fs_code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Unit clock, faster than every gated clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | NUM_OUT | Free-running source clocks, one per general output |
| ref_clk_i | input | 1 | Reference clock used in bypass mode |
| sio_base_i | input | 1 | Base clock for the super-I/O output |
| out_en_i | input | NUM_OUT | Per-output enable, 1 = running |
| sio_en_i | input | 1 | Super-I/O output enable |
| sio_half_i | input | 1 | 1 = halved base clock, 0 = base clock |
| hiz_i | input | 1 | Release all outputs to high impedance |
| bypass_i | input | 1 | All outputs copy the reference clock |
| strap_i | input | STRAP_W | Strap levels, captured once after reset |
| fs_ovr_i | input | 1 | 1 = frequency code from register bits |
| fs_reg_i | input | CODE_W | Register frequency code |
| clk_o | output | NUM_OUT | Gated general clock outputs |
| clk_oe_o | output | NUM_OUT | Output-enable for each general output |
| sio_clk_o | output | 1 | Gated super-I/O clock |
| sio_oe_o | output | 1 | Output-enable for the super-I/O pin |
| fs_code_o | output | CODE_W | Frequency code for the synthesizer |

## Verification
Every clock output is one register after its source, so a general output is due one `clk_i` cycle after the source level it copies. The bench drives sources just after each rising edge and compares, at each falling edge, against the source level it saved one falling edge earlier. Mode changes and `fs_code_o` are also due one cycle after the control, and the bench waits at least two cycles before sampling them. Enable and half-select changes settle at the next low phase of the affected clock, up to a full source period later. Those are checked through the lengths of whole high pulses, not through single-cycle comparisons.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int STRAP_W = 4;
  localparam int CODE_W  = 5;

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_TEST = 2'd1,
    MODE_HIZ  = 2'd2
  } out_mode_e;
endpackage

// File: rtl/ckg_gate_cell.sv
module ckg_gate_cell
  import ckg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      src_i,
  input  logic      ref_i,
  input  logic      en_i,
  input  out_mode_e mode_i,
  output logic      out_o,
  output logic      oe_o
);
  logic en_q, out_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b1;
      out_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      // enable is only re-sampled in the low phase of the source
      if (!src_i) en_q <= en_i;
      oe_q <= (mode_i != MODE_HIZ);
      unique case (mode_i)
        MODE_HIZ:  out_q <= 1'b0;
        MODE_TEST: out_q <= ref_i;
        default:   out_q <= src_i & en_q;
      endcase
    end
  end

  assign out_o = out_q;
  assign oe_o  = oe_q;

  assert_no_runt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(out_o) && $past(mode_i) == MODE_NORM && $past(mode_i, 2) == MODE_NORM)
    |-> !$past(src_i));

  assert_hiz_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HIZ) |=> (!oe_o && !out_o));

  assert_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TEST) |=> (out_o == $past(ref_i)));
endmodule

// File: rtl/ckg_sio_sel.sv
module ckg_sio_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic base_i,
  input  logic half_i,
  output logic src_o
);
  logic base_d, div_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_d <= 1'b0;
      div_q  <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      base_d <= base_i;
      if (base_i && !base_d) div_q <= ~div_q;
      // switch only while both candidates are low
      if (!base_i && !div_q) sel_q <= half_i;
    end
  end

  assign src_o = sel_q ? div_q : base_i;

  assert_sel_switch_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> $past(!base_i && !div_q));

  assert_div_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(base_i) |=> (div_q != $past(div_q)));
endmodule

// File: rtl/ckg_fs_sel.sv
module ckg_fs_sel
  import ckg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               ovr_i,
  input  logic [CODE_W-1:0]  reg_i,
  output logic [CODE_W-1:0]  code_o
);
  localparam int PAD_W = CODE_W - STRAP_W;

  logic [STRAP_W-1:0] strap_q;
  logic               got_q;
  logic [CODE_W-1:0]  code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0;
      got_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      if (!got_q) begin
        strap_q <= strap_i;
        got_q   <= 1'b1;
      end
      code_q <= ovr_i ? reg_i : {{PAD_W{1'b0}}, strap_q};
    end
  end

  assign code_o = code_q;

  assert_strap_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    got_q |=> $stable(strap_q));

  assert_strap_msb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_i |=> !code_o[CODE_W-1]);
endmodule

// File: rtl/ckg_top.sv
module ckg_top
  import ckg_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OUT-1:0] src_clk_i,
  input  logic               ref_clk_i,
  input  logic               sio_base_i,
  input  logic [NUM_OUT-1:0] out_en_i,
  input  logic               sio_en_i,
  input  logic               sio_half_i,
  input  logic               hiz_i,
  input  logic               bypass_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               fs_ovr_i,
  input  logic [CODE_W-1:0]  fs_reg_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o,
  output logic               sio_clk_o,
  output logic               sio_oe_o,
  output logic [CODE_W-1:0]  fs_code_o
);
  out_mode_e mode;
  logic      sio_src;

  // high impedance wins over bypass, bypass wins over gating
  always_comb begin
    if (hiz_i)         mode = MODE_HIZ;
    else if (bypass_i) mode = MODE_TEST;
    else               mode = MODE_NORM;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    ckg_gate_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_clk_i[k]),
      .ref_i  (ref_clk_i),
      .en_i   (out_en_i[k]),
      .mode_i (mode),
      .out_o  (clk_o[k]),
      .oe_o   (clk_oe_o[k])
    );
  end

  ckg_sio_sel u_sio_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .base_i (sio_base_i),
    .half_i (sio_half_i),
    .src_o  (sio_src)
  );

  ckg_gate_cell u_sio_cell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (sio_src),
    .ref_i  (ref_clk_i),
    .en_i   (sio_en_i),
    .mode_i (mode),
    .out_o  (sio_clk_o),
    .oe_o   (sio_oe_o)
  );

  ckg_fs_sel u_fs_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (strap_i),
    .ovr_i   (fs_ovr_i),
    .reg_i   (fs_reg_i),
    .code_o  (fs_code_o)
  );
endmodule

// File: tb/ckg_top_tb_top.sv
`timescale 1ns/1ps
module ckg_top_tb_top;
  localparam int NUM_OUT = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] ph = '0;
  logic [NUM_OUT-1:0] out_en = '1;
  logic sio_en = 1'b1, sio_half = 1'b1, hiz = 1'b0, bypass = 1'b0;
  logic [3:0] strap = 4'b1011;
  logic fs_ovr = 1'b0;
  logic [4:0] fs_reg = 5'b10110;

  logic [NUM_OUT-1:0] clk_o, clk_oe_o;
  logic sio_clk_o, sio_oe_o;
  logic [4:0] fs_code_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) ph <= #1 ph + 4'd1;

  ckg_top #(.NUM_OUT(NUM_OUT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .src_clk_i(ph[NUM_OUT-1:0]), .ref_clk_i(~ph[1]),
    .sio_base_i(ph[1]), .out_en_i(out_en), .sio_en_i(sio_en), .sio_half_i(sio_half),
    .hiz_i(hiz), .bypass_i(bypass), .strap_i(strap), .fs_ovr_i(fs_ovr), .fs_reg_i(fs_reg),
    .clk_o(clk_o), .clk_oe_o(clk_oe_o), .sio_clk_o(sio_clk_o), .sio_oe_o(sio_oe_o),
    .fs_code_o(fs_code_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // compares clk_o against the source level saved one falling edge earlier
  task automatic follow(input int n, input logic [NUM_OUT-1:0] mask, input string req);
    logic [NUM_OUT-1:0] prev;
    bit ok = 1;
    logic [31:0] a = 0, e = 0;
    @(negedge clk);
    prev = ph[NUM_OUT-1:0];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_o !== (prev & mask) || clk_oe_o !== '1) begin
        ok = 0; a = {clk_oe_o, clk_o}; e = {4'hf, prev & mask};
      end
      prev = ph[NUM_OUT-1:0];
    end
    check(ok, req, a, e);
  endtask

  task automatic sio_runs(input int n, output int mn, output int mx, output int cnt);
    int len = 0;
    bit started = 0;
    mn = 999; mx = 0; cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sio_clk_o) begin
        if (started) len++;
      end else begin
        if (len > 0) begin
          cnt++;
          if (len < mn) mn = len;
          if (len > mx) mx = len;
        end
        started = 1; len = 0;
      end
    end
  endtask

  task automatic t_reset();
    #7;
    check(clk_o === '0 && sio_clk_o === 1'b0, "R1 outputs low in reset", {sio_clk_o, clk_o}, 0);
    check(clk_oe_o === '1 && sio_oe_o === 1'b1, "R1 oe high in reset", {sio_oe_o, clk_oe_o}, 5'h1f);
    check(fs_code_o === 5'd0, "R1 fs code in reset", fs_code_o, 0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_defaults();
    int mn, mx, cnt;
    follow(24, '1, "R1 R2 enabled after reset follows source");
    sio_runs(40, mn, mx, cnt);
    check(cnt > 0 && mn == 4 && mx == 4, "R1 R7 sio defaults to halved clock", mx, 4);
  endtask

  task automatic t_disable();
    out_en = 4'b0101;
    wait_neg(20);
    follow(32, 4'b0101, "R3 disabled outputs held low");
    out_en = '1;
    wait_neg(20);
    follow(16, '1, "R2 re-enabled outputs follow");
  endtask

  task automatic t_no_runt();
    int len = 0, cnt = 0;
    bit started = 0, ok = 1;
    int bad = 0;
    for (int i = 0; i < 240; i++) begin
      @(negedge clk);
      if (clk_o[3]) begin
        if (started) len++;
      end else begin
        if (len > 0) begin
          cnt++;
          if (len != 8) begin ok = 0; bad = len; end
        end
        started = 1; len = 0;
      end
      if (i % 13 == 5) out_en[3] = ~out_en[3];
    end
    check(ok && cnt > 0, "R4 no shortened pulse on enable toggles", bad, 8);
    out_en = '1;
    wait_neg(20);
  endtask

  task automatic t_hiz();
    hiz = 1'b1; bypass = 1'b1;
    wait_neg(2);
    check(clk_oe_o === '0 && sio_oe_o === 1'b0, "R5 all oe low", {sio_oe_o, clk_oe_o}, 0);
    check(clk_o === '0 && sio_clk_o === 1'b0, "R5 outputs low over bypass", {sio_clk_o, clk_o}, 0);
    hiz = 1'b0; bypass = 1'b0;
    wait_neg(2);
    check(clk_oe_o === '1 && sio_oe_o === 1'b1, "R5 oe restored", {sio_oe_o, clk_oe_o}, 5'h1f);
  endtask

  task automatic t_bypass();
    logic prev;
    bit ok = 1;
    logic [31:0] a = 0, e = 0;
    out_en = '0; sio_en = 1'b0; bypass = 1'b1;
    wait_neg(2);
    prev = ~ph[1];
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (clk_o !== {NUM_OUT{prev}} || sio_clk_o !== prev) begin
        ok = 0; a = {sio_clk_o, clk_o}; e = {5{prev}};
      end
      prev = ~ph[1];
    end
    check(ok, "R6 bypass copies reference ignoring enables", a, e);
    bypass = 1'b0; out_en = '1; sio_en = 1'b1;
    wait_neg(20);
  endtask

  task automatic t_sio();
    int mn, mx, cnt;
    sio_half = 1'b0;
    wait_neg(12);
    sio_runs(40, mn, mx, cnt);
    check(cnt > 0 && mn == 2 && mx == 2, "R7 sio base rate", mx, 2);
    sio_half = 1'b1;
    wait_neg(12);
    sio_runs(40, mn, mx, cnt);
    check(cnt > 0 && mn == 4 && mx == 4, "R7 sio halved rate", mx, 4);
    mn = 999; mx = 0;
    for (int k = 0; k < 12; k++) begin
      int m1, x1, c1;
      sio_half = ~sio_half;
      sio_runs(7 + k, m1, x1, c1);
      if (c1 > 0 && m1 < mn) mn = m1;
      if (x1 > mx) mx = x1;
    end
    check(mn >= 2 && mx <= 4, "R8 no runt on sio reselect", mn, 2);
    sio_half = 1'b1;
    wait_neg(12);
  endtask

  task automatic t_fs();
    check(fs_code_o === 5'b01011, "R9 strap path with msb zero", fs_code_o, 5'b01011);
    strap = 4'b0100;
    wait_neg(4);
    check(fs_code_o === 5'b01011, "R10 later strap change ignored", fs_code_o, 5'b01011);
    fs_ovr = 1'b1;
    wait_neg(2);
    check(fs_code_o === 5'b10110, "R9 register path", fs_code_o, 5'b10110);
    fs_reg = 5'b11111;
    wait_neg(2);
    check(fs_code_o === 5'b11111, "R9 register path all ones", fs_code_o, 5'b11111);
    fs_ovr = 1'b0;
    wait_neg(2);
    check(fs_code_o === 5'b01011, "R9 R10 back to latched straps", fs_code_o, 5'b01011);
  endtask

  initial begin
    t_reset();
    wait_neg(3);
    t_defaults();
    t_disable();
    t_no_runt();
    t_hiz();
    t_bypass();
    t_sio();
    t_fs();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule